// File: doc/BRIEF.md
# Dual-Channel Block Interleave Router

This block decides, for every 64-byte block of a linear physical memory image, which of two memory channels produced it. With two channels, each channel scrambles with its own independent key stream. A 64-byte subkey covers each block. The channel of a block follows a self-similar pattern of order `ORDER`. The order-1 pattern (type Q) is A,A,B,B and its complement (type R) is B,B,A,A. Each higher order is built as Q(n) = Q(n-1) R(n-1) R(n-1) Q(n-1) and R(n) = R(n-1) Q(n-1) Q(n-1) R(n-1). The full pattern covers 4^ORDER blocks. A 4 GiB two-channel image needs order 13.

The block offers three paths. A combinational lookup gives the channel of any block index. A streaming splitter takes a beat stream in image order and steers each whole block to the channel A or the channel B output, so each channel's blocks form a contiguous stream that can be descrambled with that channel's subkey alone. A streaming joiner does the reverse: it pulls blocks from the two per-channel streams in pattern order and rebuilds the image-order stream. A block is 64 bytes, carried as `64*8/DATA_W` beats.

Top module: `ilv_channel_router`

## Requirements
- R1: `lookupChan` is a combinational function of `lookupIdx`, with 0 meaning channel A and 1 meaning channel B. For ORDER = 1, indices 0 and 1 give 0 and indices 2 and 3 give 1.
- R2: For ORDER > 1, the index is read as ORDER base-4 digits. The top digit selects the quarter: quarters 0 and 3 repeat the order-(n-1) pattern, and quarters 1 and 2 repeat its complement. Indices cover 0 to 4^ORDER-1 (width 2*ORDER).
- R3: The splitter groups accepted beats (`inValid` high) into blocks of BEATS = 512/DATA_W beats. Every beat of a block goes to the channel that the R1/R2 pattern gives for the image block counter, which is 0 after reset. Cycles with `inValid` low do not advance any counter and produce no output.
- R4: A beat accepted at a clock edge appears at the next edge on exactly one of `aValid`/`bValid`, with `aData`/`bData` equal to `inData`. The two valids are never high together.
- R5: `aBlk` (`bBlk`) carries the number of channel A (B) blocks that completed before the current one, so each channel's block numbering is contiguous from 0.
- R6: Exactly one of `mAReady`/`mBReady` is high. The high one names the channel that the pattern gives for the joiner's image block counter (0 after reset). A beat taken from that channel appears on `outData` one edge later with `outValid` high, and `outBlk` equal to its image block index.
- R7: While the selected channel's valid is low, the joiner emits nothing and holds its position. A valid beat on the unselected channel is ignored.
- R8: The image block counters of the splitter and of the joiner wrap to 0 after 4^ORDER blocks, and the pattern then restarts.
- R9: After reset, `aValid`, `bValid` and `outValid` are 0, and `mAReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupIdx | input | 2*ORDER | Block index to classify |
| lookupChan | output | 1 | Channel of `lookupIdx` (0 = A, 1 = B) |
| inValid | input | 1 | Image-order beat present |
| inData | input | DATA_W | Image-order beat data |
| aValid | output | 1 | Splitter beat for channel A |
| aData | output | DATA_W | Channel A beat data |
| aBlk | output | 2*ORDER | Channel A block number |
| bValid | output | 1 | Splitter beat for channel B |
| bData | output | DATA_W | Channel B beat data |
| bBlk | output | 2*ORDER | Channel B block number |
| mAValid | input | 1 | Joiner channel A beat present |
| mAData | input | DATA_W | Joiner channel A beat data |
| mAReady | output | 1 | Joiner takes channel A now |
| mBValid | input | 1 | Joiner channel B beat present |
| mBData | input | DATA_W | Joiner channel B beat data |
| mBReady | output | 1 | Joiner takes channel B now |
| outValid | output | 1 | Rejoined beat present |
| outData | output | DATA_W | Rejoined beat data |
| outBlk | output | 2*ORDER | Image block index of rejoined beat |

## Verification
A wrong beat-within-block count shows on the next edge: a beat of a block lands on the other channel, and every later block boundary is offset. A wrong image block counter or pattern digit shows within one block as a swapped channel, while a wrong per-channel counter shows as a gap or a repeat in `aBlk`/`bBlk` at the next block of that channel. A joiner that advances on an ignored or absent beat shows at once: the ready line points at the wrong channel, or `outBlk` skips an index.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic toA;    // accepted input beat goes to channel A
    logic toB;    // accepted input beat goes to channel B
    logic take;   // joiner consumes a beat this cycle
    logic takeB;  // joiner source is channel B
  } ilv_strobe_t;
endpackage

// File: rtl/ilv_pattern.sv
module ilv_pattern #(
  parameter int ORDER = 13
) (
  input  logic [2*ORDER-1:0] idx,
  output logic               chan
);
  // Each base-4 digit above the lowest flips Q/R when it is 1 or 2;
  // the lowest digit picks A (0,1) or B (2,3) inside the base pattern.
  logic [ORDER-1:0] term;

  genvar j;
  generate
    for (j = 0; j < ORDER; j++) begin : g_digit
      if (j == 0) begin : g_leaf
        assign term[j] = idx[1];
      end else begin : g_flip
        assign term[j] = idx[2*j] ^ idx[2*j+1];
      end
    end
  endgenerate

  assign chan = ^term;
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int ORDER = 13,
  parameter int BEATS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                mAValid,
  input  logic                mBValid,
  output ilv_strobe_t         strb,
  output logic [2*ORDER-1:0]  aBlkCnt,
  output logic [2*ORDER-1:0]  bBlkCnt,
  output logic [2*ORDER-1:0]  mergeBlkCnt,
  output logic                mAReady,
  output logic                mBReady
);
  localparam int IDX_W  = 2 * ORDER;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] inBeat;
  logic [BEAT_W-1:0] mBeat;
  logic [IDX_W-1:0]  inBlk;
  logic              demuxChan;
  logic              mergeChan;
  logic              inLast;
  logic              mLast;

  ilv_pattern #(.ORDER(ORDER)) u_demuxPat (.idx(inBlk),       .chan(demuxChan));
  ilv_pattern #(.ORDER(ORDER)) u_mergePat (.idx(mergeBlkCnt), .chan(mergeChan));

  assign inLast = (inBeat == LAST_BEAT);
  assign mLast  = (mBeat == LAST_BEAT);

  always_comb begin
    strb.toA   = inValid & ~demuxChan;
    strb.toB   = inValid &  demuxChan;
    strb.takeB = mergeChan;
    strb.take  = mergeChan ? mBValid : mAValid;
  end

  assign mAReady = ~mergeChan;
  assign mBReady =  mergeChan;

  // Splitter counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBeat  <= '0;
      inBlk   <= '0;
      aBlkCnt <= '0;
      bBlkCnt <= '0;
    end else if (inValid) begin
      inBeat <= inLast ? '0 : inBeat + 1'b1;
      if (inLast) begin
        inBlk <= inBlk + 1'b1;
        if (demuxChan) bBlkCnt <= bBlkCnt + 1'b1;
        else           aBlkCnt <= aBlkCnt + 1'b1;
      end
    end
  end

  // Joiner counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mBeat       <= '0;
      mergeBlkCnt <= '0;
    end else if (strb.take) begin
      mBeat <= mLast ? '0 : mBeat + 1'b1;
      if (mLast) mergeBlkCnt <= mergeBlkCnt + 1'b1;
    end
  end

  // R3
  demux_blk_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inBeat != '0) |-> $stable(demuxChan));

  // R5
  a_cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aBlkCnt != $past(aBlkCnt)) |-> $past(strb.toA && inLast));

  // R5
  b_cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bBlkCnt != $past(bBlkCnt)) |-> $past(strb.toB && inLast));

  // R7
  merge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(mergeChan ? mBValid : mAValid) |=> $stable(mergeBlkCnt) && $stable(mBeat));
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int ORDER  = 13,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  ilv_strobe_t         strb,
  input  logic [DATA_W-1:0]   inData,
  input  logic [DATA_W-1:0]   mAData,
  input  logic [DATA_W-1:0]   mBData,
  input  logic [2*ORDER-1:0]  aBlkCnt,
  input  logic [2*ORDER-1:0]  bBlkCnt,
  input  logic [2*ORDER-1:0]  mergeBlkCnt,
  output logic                aValid,
  output logic [DATA_W-1:0]   aData,
  output logic [2*ORDER-1:0]  aBlk,
  output logic                bValid,
  output logic [DATA_W-1:0]   bData,
  output logic [2*ORDER-1:0]  bBlk,
  output logic                outValid,
  output logic [DATA_W-1:0]   outData,
  output logic [2*ORDER-1:0]  outBlk
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid <= 1'b0;
      aData  <= '0;
      aBlk   <= '0;
    end else begin
      aValid <= strb.toA;
      if (strb.toA) begin
        aData <= inData;
        aBlk  <= aBlkCnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValid <= 1'b0;
      bData  <= '0;
      bBlk   <= '0;
    end else begin
      bValid <= strb.toB;
      if (strb.toB) begin
        bData <= inData;
        bBlk  <= bBlkCnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outBlk   <= '0;
    end else begin
      outValid <= strb.take;
      if (strb.take) begin
        outData <= strb.takeB ? mBData : mAData;
        outBlk  <= mergeBlkCnt;
      end
    end
  end

  // R4
  demux_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aValid, bValid}));
endmodule

// File: rtl/ilv_channel_router.sv
module ilv_channel_router
  import ilv_pkg::*;
#(
  parameter int ORDER  = 13,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2*ORDER-1:0]  lookupIdx,
  output logic                lookupChan,
  input  logic                inValid,
  input  logic [DATA_W-1:0]   inData,
  output logic                aValid,
  output logic [DATA_W-1:0]   aData,
  output logic [2*ORDER-1:0]  aBlk,
  output logic                bValid,
  output logic [DATA_W-1:0]   bData,
  output logic [2*ORDER-1:0]  bBlk,
  input  logic                mAValid,
  input  logic [DATA_W-1:0]   mAData,
  output logic                mAReady,
  input  logic                mBValid,
  input  logic [DATA_W-1:0]   mBData,
  output logic                mBReady,
  output logic                outValid,
  output logic [DATA_W-1:0]   outData,
  output logic [2*ORDER-1:0]  outBlk
);
  localparam int IDX_W = 2 * ORDER;
  localparam int BEATS = 512 / DATA_W;

  ilv_strobe_t      strb;
  logic [IDX_W-1:0] aBlkCnt;
  logic [IDX_W-1:0] bBlkCnt;
  logic [IDX_W-1:0] mergeBlkCnt;

  ilv_pattern #(.ORDER(ORDER)) u_lookupPat (.idx(lookupIdx), .chan(lookupChan));

  ilv_ctrl #(.ORDER(ORDER), .BEATS(BEATS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .mAValid(mAValid), .mBValid(mBValid), .strb(strb),
    .aBlkCnt(aBlkCnt), .bBlkCnt(bBlkCnt), .mergeBlkCnt(mergeBlkCnt),
    .mAReady(mAReady), .mBReady(mBReady)
  );

  ilv_datapath #(.ORDER(ORDER), .DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .mAData(mAData), .mBData(mBData),
    .aBlkCnt(aBlkCnt), .bBlkCnt(bBlkCnt), .mergeBlkCnt(mergeBlkCnt),
    .aValid(aValid), .aData(aData), .aBlk(aBlk),
    .bValid(bValid), .bData(bData), .bBlk(bBlk),
    .outValid(outValid), .outData(outData), .outBlk(outBlk)
  );

  // R6
  out_src_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(mAReady ? mAValid : mBValid));

  // R6
  out_data_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData == $past(mAReady ? mAData : mBData)));
endmodule

// File: tb/ilv_channel_router_bench.sv
module ilv_channel_router_bench;
  localparam int ORD   = 13;
  localparam int IW    = 2 * ORD;
  localparam int DW    = 64;
  localparam int BEATS = 512 / DW;
  localparam int SDW   = 256;
  localparam int SBEATS = 512 / SDW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // main instance
  logic [IW-1:0] lookupIdx = '0;
  logic lookupChan;
  logic inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic aValid, bValid, outValid, mAReady, mBReady;
  logic [DW-1:0] aData, bData, outData;
  logic [IW-1:0] aBlk, bBlk, outBlk;
  logic mAValid = 1'b0, mBValid = 1'b0;
  logic [DW-1:0] mAData = '0, mBData = '0;

  ilv_channel_router #(.ORDER(ORD), .DATA_W(DW)) u_ilv_channel_router (
    .clk(clk), .rstN(rstN), .lookupIdx(lookupIdx), .lookupChan(lookupChan),
    .inValid(inValid), .inData(inData),
    .aValid(aValid), .aData(aData), .aBlk(aBlk),
    .bValid(bValid), .bData(bData), .bBlk(bBlk),
    .mAValid(mAValid), .mAData(mAData), .mAReady(mAReady),
    .mBValid(mBValid), .mBData(mBData), .mBReady(mBReady),
    .outValid(outValid), .outData(outData), .outBlk(outBlk)
  );

  // order-1 instance for wrap checks
  logic [1:0] sIdx = '0;
  logic sChan;
  logic sInValid = 1'b0;
  logic [SDW-1:0] sInData = '0;
  logic sAValid, sBValid, sOutValid, sAReady, sBReady;
  logic [SDW-1:0] sAData, sBData, sOutData;
  logic [1:0] sABlk, sBBlk, sOutBlk;
  logic sMAValid = 1'b0, sMBValid = 1'b0;
  logic [SDW-1:0] sMAData = '0, sMBData = '0;

  ilv_channel_router #(.ORDER(1), .DATA_W(SDW)) u_small (
    .clk(clk), .rstN(rstN), .lookupIdx(sIdx), .lookupChan(sChan),
    .inValid(sInValid), .inData(sInData),
    .aValid(sAValid), .aData(sAData), .aBlk(sABlk),
    .bValid(sBValid), .bData(sBData), .bBlk(sBBlk),
    .mAValid(sMAValid), .mAData(sMAData), .mAReady(sAReady),
    .mBValid(sMBValid), .mBData(sMBData), .mBReady(sBReady),
    .outValid(sOutValid), .outData(sOutData), .outBlk(sOutBlk)
  );

  // Reference pattern written from the recursive definition
  function automatic bit refChan(int n, longint k);
    longint sz = longint'(1) << (2 * (n - 1));
    longint full = sz * 4;
    longint kk = k % full;
    longint q;
    bit sub;
    if (n == 1) return (kk >= 2);
    q = kk / sz;
    sub = refChan(n - 1, kk % sz);
    return (q == 1 || q == 2) ? !sub : sub;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(aValid == 1'b0 && bValid == 1'b0, "R9 splitter valids", {aValid, bValid}, 0);
    chk(outValid == 1'b0, "R9 outValid", outValid, 0);
    chk(mAReady == 1'b1 && mBReady == 1'b0, "R9 ready A", {mAReady, mBReady}, 2);
    chk(sAReady == 1'b1, "R9 small ready A", sAReady, 1);
  endtask

  task automatic t_lookup;
    longint k;
    longint lcg = 12345;
    for (int i = 0; i < 4; i++) begin
      sIdx = 2'(i);
      #1;
      chk(sChan == refChan(1, i), "R1 order-1 base", sChan, refChan(1, i));
    end
    for (int i = 0; i < 16; i++) begin
      lookupIdx = IW'(i);
      #1;
      chk(lookupChan == refChan(ORD, i), "R1 low indices", lookupChan, refChan(ORD, i));
    end
    for (int i = 0; i < 40; i++) begin
      lcg = (lcg * 1103515245 + 12345) % (longint'(1) << 31);
      k = lcg % (longint'(1) << IW);
      if (i == 0) k = (longint'(1) << IW) - 1;
      if (i == 1) k = longint'(1) << (IW - 2);
      if (i == 2) k = (longint'(2) << (IW - 2)) + 3;
      lookupIdx = IW'(k);
      #1;
      chk(lookupChan == refChan(ORD, k), "R2 recursive index", lookupChan, refChan(ORD, k));
    end
  endtask

  // Splitter over 20 blocks with idle gaps
  task automatic t_demux;
    int cntA = 0;
    int cntB = 0;
    int seq = 0;
    bit ec;
    for (int blk = 0; blk < 20; blk++) begin
      ec = refChan(ORD, blk);
      for (int bt = 0; bt < BEATS; bt++) begin
        @(negedge clk);
        inValid = 1'b1;
        inData  = 64'hC0DE_0000_0000_0000 | DW'(seq);
        @(posedge clk);
        #1;
        if (ec) begin
          chk(bValid && !aValid, "R3 beat on B", {aValid, bValid}, 1);
          chk(bData == inData, "R4 B data", bData, inData);
          chk(bBlk == IW'(cntB), "R5 B block number", bBlk, cntB);
        end else begin
          chk(aValid && !bValid, "R3 beat on A", {aValid, bValid}, 2);
          chk(aData == inData, "R4 A data", aData, inData);
          chk(aBlk == IW'(cntA), "R5 A block number", aBlk, cntA);
        end
        seq++;
        if (seq % 3 == 0) begin
          @(negedge clk);
          inValid = 1'b0;
          @(posedge clk);
          #1;
          chk(!aValid && !bValid, "R3 idle no output", {aValid, bValid}, 0);
        end
      end
      if (ec) cntB++; else cntA++;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Joiner over 20 blocks, with stalls
  task automatic t_merge;
    int aNext = 0;
    int bNext = 0;
    bit ec;
    logic [DW-1:0] expD;
    for (int blk = 0; blk < 20; blk++) begin
      ec = refChan(ORD, blk);
      for (int bt = 0; bt < BEATS; bt++) begin
        if (bt == 3) begin
          @(negedge clk);
          mAValid = ec;
          mBValid = !ec;
          mAData  = 64'hDEAD_0000_0000_0000;
          mBData  = 64'hDEAD_0000_0000_0001;
          @(posedge clk);
          #1;
          chk(!outValid, "R7 stall no output", outValid, 0);
          chk(mBReady == ec, "R7 position held", mBReady, ec);
        end
        @(negedge clk);
        mAValid = 1'b1;
        mBValid = 1'b1;
        mAData  = 64'hAAAA_0000_0000_0000 | DW'(aNext);
        mBData  = 64'hBBBB_0000_0000_0000 | DW'(bNext);
        #1;
        chk(mBReady == ec && mAReady == !ec, "R6 ready follows pattern", {mAReady, mBReady}, ec ? 1 : 2);
        expD = ec ? mBData : mAData;
        @(posedge clk);
        #1;
        chk(outValid, "R6 outValid", outValid, 1);
        chk(outData == expD, "R6 outData", outData, expD);
        chk(outBlk == IW'(blk), "R6 outBlk", outBlk, blk);
        if (ec) bNext++; else aNext++;
      end
    end
    @(negedge clk);
    mAValid = 1'b0;
    mBValid = 1'b0;
  endtask

  // Order-1 wrap after 4 blocks
  task automatic t_wrap;
    int cntA = 0;
    int cntB = 0;
    bit ec;
    for (int blk = 0; blk < 6; blk++) begin
      ec = refChan(1, blk);
      for (int bt = 0; bt < SBEATS; bt++) begin
        @(negedge clk);
        sInValid = 1'b1;
        sInData  = SDW'(blk * 16 + bt);
        @(posedge clk);
        #1;
        chk(sBValid == ec && sAValid == !ec, "R8 splitter wrap channel", {sAValid, sBValid}, ec ? 1 : 2);
        if (ec) chk(sBBlk == 2'(cntB), "R8 B count", sBBlk, cntB);
        else    chk(sABlk == 2'(cntA), "R8 A count", sABlk, cntA);
      end
      if (ec) cntB++; else cntA++;
    end
    @(negedge clk);
    sInValid = 1'b0;
    for (int blk = 0; blk < 6; blk++) begin
      ec = refChan(1, blk);
      for (int bt = 0; bt < SBEATS; bt++) begin
        @(negedge clk);
        sMAValid = 1'b1;
        sMBValid = 1'b1;
        #1;
        chk(sBReady == ec, "R8 joiner wrap ready", sBReady, ec);
        @(posedge clk);
        #1;
        chk(sOutBlk == 2'(blk % 4), "R8 joiner wrap block", sOutBlk, blk % 4);
      end
    end
    @(negedge clk);
    sMAValid = 1'b0;
    sMBValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_lookup();
    t_demux();
    t_merge();
    t_wrap();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule